// File: doc/BRIEF.md
# Cascadable Presettable Counter Stage

This block is one digit of a synchronous counter. It holds a small count that advances by one on a rising clock edge when two count enables are both high. It can be preset from a parallel data input through an active-low load, and cleared through an active-low reset. Two elaboration choices select its character. The first is a modulus: either binary, where the count runs through the full range of its width, or decade, where a 4-bit digit runs from 0 to 9. The second is the reset style: either asynchronous, where the clear acts at once, or synchronous, where the clear waits for the next rising edge.

Wider counters are built by chaining stages. Each stage drives a carry output that is high when its trickle enable is high and its count sits at the modulus maximum. That carry feeds the trickle enable of the next stage, and all stages share one parallel enable. Only the trickle enable reaches the carry, so a chain can be stopped through the shared parallel enable without any change rippling along the carry path.

Top module: `sync_preset_counter`

## Requirements
- R1: An active-low `rst_n` sets the count to 0 and takes priority over every other input. With ASYNC_RST=1 the count clears as soon as `rst_n` falls, with no clock edge. With ASYNC_RST=0 the count clears on the first rising edge at which `rst_n` is sampled low.
- R2: When `rst_n` is high and `load_n` is low, the next rising edge loads `din` into the count, whatever the count enables are.
- R3: When `rst_n` and `load_n` are high and both `en_par` and `en_trk` are high, a count below the modulus maximum increases by exactly one on each rising edge.
- R4: When `rst_n` and `load_n` are high and at least one of `en_par` and `en_trk` is low, the count holds its value across the edge.
- R5: In binary mode (DECADE=0) a counting edge at the maximum value 2^W-1 returns the count to 0.
- R6: In decade mode (DECADE=1) a counting edge at 9 returns the count to 0.
- R7: In decade mode, a counting edge on a count above 9 behaves as follows. An even value (10, 12, 14) goes to the value plus one. An odd value (11, 13, 15) goes to the value plus one, taken modulo 8, so 11 becomes 4, 13 becomes 6 and 15 becomes 0. Any count therefore returns to 0..9 within two counting edges.
- R8: `carry_out` is combinational. It is high exactly when `en_trk` is high and the count equals the modulus maximum (9 in decade mode, 2^W-1 in binary mode), and `en_par` has no effect on it.
- R9: Two stages form a counter of twice the width when the lower stage's `carry_out` drives the upper stage's `en_trk` and `en_par` and `load_n` are shared. Such a pair counts 0..2^(2W)-1 in binary mode and 00..99 in decade mode, and wraps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its rising edge |
| rst_n | input | 1 | Active-low clear; asynchronous or synchronous according to ASYNC_RST |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_par | input | 1 | Parallel count enable, shared by all stages of a chain |
| en_trk | input | 1 | Trickle count enable; also gates carry_out |
| din | input | W | Parallel data loaded when load_n is low |
| count | output | W | Current count |
| carry_out | output | 1 | Terminal-count carry to the next stage |

## Verification
The bench builds four instances, all with W=4. Two are binary stages with ASYNC_RST=1, chained into an 8-bit counter. The other two are decade stages with ASYNC_RST=0, chained into a two-digit counter. Running the two pairs together from one reset pulse shows the difference between the reset styles in the same cycle: the binary count drops between edges while the decade count waits for the edge. The long counting run carries both chains through their full wrap. The decade pair also makes the six out-of-range digit values reachable by parallel load, so their return path can be followed.

// File: rtl/spc_pkg.sv
package spc_pkg;

  // Operation chosen for the next clock edge, lowest to highest priority.
  typedef enum logic [1:0] {
    SPC_HOLD  = 2'd0,
    SPC_COUNT = 2'd1,
    SPC_LOAD  = 2'd2,
    SPC_CLEAR = 2'd3
  } spc_op_e;

  // Largest legal count for the chosen modulus.
  function automatic int unsigned spc_top_value(bit decade, int unsigned w);
    if (decade) return 9;
    return (32'd1 << w) - 32'd1;
  endfunction

  // Value after one counting edge.
  function automatic int unsigned spc_advance(int unsigned v, bit decade, int unsigned w);
    int unsigned top;
    top = spc_top_value(decade, w);
    if (v == top) return 0;
    if (!decade) return (v + 1) & top;
    if (v < 9) return v + 1;
    // out-of-range decade digit: even steps up, odd folds into 0..7
    if (v[0]) return (v + 1) & 32'd7;
    return v + 1;
  endfunction

endpackage

// File: rtl/spc_decode.sv
module spc_decode
  import spc_pkg::*;
(
  input  logic    rst_n,
  input  logic    load_n,
  input  logic    en_par,
  input  logic    en_trk,
  output spc_op_e op
);

  always_comb begin
    if (!rst_n)                op = SPC_CLEAR;
    else if (!load_n)          op = SPC_LOAD;
    else if (en_par && en_trk) op = SPC_COUNT;
    else                       op = SPC_HOLD;
  end

endmodule

// File: rtl/spc_next.sv
module spc_next
  import spc_pkg::*;
#(
  parameter int unsigned W      = 4,
  parameter bit          DECADE = 1'b0
) (
  input  spc_op_e        op,
  input  logic [W-1:0]   cur,
  input  logic [W-1:0]   din,
  output logic [W-1:0]   nxt
);

  logic [W-1:0] stepped;

  always_comb begin
    stepped = W'(spc_advance(32'(cur), DECADE, W));
    case (op)
      SPC_CLEAR: nxt = '0;
      SPC_LOAD:  nxt = din;
      SPC_COUNT: nxt = stepped;
      default:   nxt = cur;
    endcase
  end

endmodule

// File: rtl/spc_state.sv
module spc_state #(
  parameter int unsigned W         = 4,
  parameter bit          ASYNC_RST = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end
  endgenerate

endmodule

// File: rtl/spc_term.sv
module spc_term
  import spc_pkg::*;
#(
  parameter int unsigned W      = 4,
  parameter bit          DECADE = 1'b0
) (
  input  logic [W-1:0] cur,
  input  logic         en_trk,
  output logic         at_top,
  output logic         carry_out
);

  localparam logic [W-1:0] TOP = W'(spc_top_value(DECADE, W));

  assign at_top    = (cur == TOP);
  assign carry_out = en_trk & at_top;

endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
  import spc_pkg::*;
#(
  parameter int unsigned W         = 4,
  parameter bit          DECADE    = 1'b0,
  parameter bit          ASYNC_RST = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic         en_par,
  input  logic         en_trk,
  input  logic [W-1:0] din,
  output logic [W-1:0] count,
  output logic         carry_out
);

  spc_op_e      op;
  logic [W-1:0] nxt;
  logic         at_top;
  logic         do_count;
  logic         do_load;

  spc_decode u_decode (
    .rst_n  (rst_n),
    .load_n (load_n),
    .en_par (en_par),
    .en_trk (en_trk),
    .op     (op)
  );

  spc_next #(.W(W), .DECADE(DECADE)) u_next (
    .op  (op),
    .cur (count),
    .din (din),
    .nxt (nxt)
  );

  spc_state #(.W(W), .ASYNC_RST(ASYNC_RST)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (nxt),
    .q     (count)
  );

  spc_term #(.W(W), .DECADE(DECADE)) u_term (
    .cur       (count),
    .en_trk    (en_trk),
    .at_top    (at_top),
    .carry_out (carry_out)
  );

  // named events for the checker
  assign do_count = (op == SPC_COUNT);
  assign do_load  = (op == SPC_LOAD);

endmodule

// File: rtl/spc_checker.sv
module spc_checker
  import spc_pkg::*;
#(
  parameter int unsigned W      = 4,
  parameter bit          DECADE = 1'b0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_n,
  input logic         en_par,
  input logic         en_trk,
  input logic [W-1:0] din,
  input logic [W-1:0] count,
  input logic         carry_out,
  input logic         do_count,
  input logic         do_load,
  input logic         at_top
);

  localparam logic [W-1:0] TOP = W'(spc_top_value(DECADE, W));

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> count == '0); // R1
  AST_LOAD_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> count == $past(din)); // R2
  AST_LOAD_DECODED: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |-> do_load && !do_count); // R2
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    do_count && count < TOP |=> count == W'($past(count) + 1'b1)); // R3
  AST_COUNT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    do_count |-> en_par && en_trk && load_n); // R3
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    load_n && !(en_par && en_trk) |=> $stable(count)); // R4
  AST_TC_TRICKLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_trk |-> !carry_out); // R8
  AST_TC_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> count == TOP); // R8
  AST_TC_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    en_trk && at_top |-> carry_out); // R8

  generate
    if (DECADE) begin : g_dec
      AST_DECADE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        do_count && count == TOP |=> count == '0); // R6
      AST_ILLEGAL_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        do_count && count > TOP && !count[0] |=> count == W'($past(count) + 1'b1)); // R7
      AST_ILLEGAL_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        do_count && count > TOP && count[0] |=> count <= W'(7)); // R7
    end else begin : g_bin
      AST_BINARY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        do_count && count == TOP |=> count == '0); // R5
    end
  endgenerate

endmodule

bind sync_preset_counter spc_checker #(.W(W), .DECADE(DECADE)) u_spc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_n    (load_n),
  .en_par    (en_par),
  .en_trk    (en_trk),
  .din       (din),
  .count     (count),
  .carry_out (carry_out),
  .do_count  (do_count),
  .do_load   (do_load),
  .at_top    (at_top)
);

// File: tb/test_sync_preset_counter.sv
module test_sync_preset_counter;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_n, load_n, en_par, en_trk;
  logic [3:0] b_din_lo, b_din_hi, d_din_lo, d_din_hi;
  logic [3:0] b_lo, b_hi, d_lo, d_hi;
  logic       b_tc_lo, b_tc_hi, d_tc_lo, d_tc_hi;

  int checks = 0;
  int errors = 0;
  int bref, dref;

  // binary pair, asynchronous reset
  sync_preset_counter #(.W(4), .DECADE(1'b0), .ASYNC_RST(1'b1)) i_sync_preset_counter (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_par(en_par), .en_trk(en_trk),
    .din(b_din_lo), .count(b_lo), .carry_out(b_tc_lo));
  sync_preset_counter #(.W(4), .DECADE(1'b0), .ASYNC_RST(1'b1)) i_sync_preset_counter_bhi (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_par(en_par), .en_trk(b_tc_lo),
    .din(b_din_hi), .count(b_hi), .carry_out(b_tc_hi));
  // decade pair, synchronous reset
  sync_preset_counter #(.W(4), .DECADE(1'b1), .ASYNC_RST(1'b0)) i_sync_preset_counter_dlo (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_par(en_par), .en_trk(en_trk),
    .din(d_din_lo), .count(d_lo), .carry_out(d_tc_lo));
  sync_preset_counter #(.W(4), .DECADE(1'b1), .ASYNC_RST(1'b0)) i_sync_preset_counter_dhi (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .en_par(en_par), .en_trk(d_tc_lo),
    .din(d_din_hi), .count(d_hi), .carry_out(d_tc_hi));

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int bin_val();
    return int'(b_hi) * 16 + int'(b_lo);
  endfunction

  function automatic int dec_val();
    return int'(d_hi) * 10 + int'(d_lo);
  endfunction

  task automatic load_all(int bv, int dv);
    load_n   = 1'b0;
    b_din_hi = 4'(bv / 16);
    b_din_lo = 4'(bv % 16);
    d_din_hi = 4'(dv / 10);
    d_din_lo = 4'(dv % 10);
    tick();
    load_n = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick(); tick();
    check("R1", "binary count after reset", bin_val(), 0);
    check("R1", "decade count after reset", dec_val(), 0);
    check("R8", "binary carry at zero", int'(b_tc_lo), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_load();
    en_par = 1'b0; en_trk = 1'b0;
    load_all(8'hA5, 73);
    check("R2", "binary load with enables low", bin_val(), 8'hA5);
    check("R2", "decade load with enables low", dec_val(), 73);
  endtask

  task automatic t_hold();
    en_par = 1'b1; en_trk = 1'b0; tick(); tick();
    check("R4", "binary hold, trickle low", bin_val(), 8'hA5);
    check("R4", "decade hold, trickle low", dec_val(), 73);
    en_par = 1'b0; en_trk = 1'b1; tick();
    check("R4", "binary hold, parallel low", bin_val(), 8'hA5);
    check("R4", "decade hold, parallel low", dec_val(), 73);
  endtask

  task automatic t_carry();
    en_par = 1'b0; en_trk = 1'b1;
    load_all(8'h3F, 19);
    check("R8", "binary carry at 15, parallel low", int'(b_tc_lo), 1);
    check("R8", "decade carry at 9, parallel low", int'(d_tc_lo), 1);
    check("R8", "upper binary carry not at top", int'(b_tc_hi), 0);
    en_trk = 1'b0; #1;
    check("R8", "binary carry with trickle low", int'(b_tc_lo), 0);
    check("R8", "decade carry with trickle low", int'(d_tc_lo), 0);
    @(negedge clk);
  endtask

  task automatic t_count();
    en_par = 1'b0; en_trk = 1'b0;
    load_all(250, 95);
    bref = 250; dref = 95;
    en_par = 1'b1; en_trk = 1'b1;
    for (int i = 0; i < 300; i++) begin
      tick();
      bref = (bref + 1) % 256;
      dref = (dref + 1) % 100;
      check("R9", "binary chain value", bin_val(), bref);
      check("R9", "decade chain value", dec_val(), dref);
      check("R8", "binary low carry", int'(b_tc_lo), int'(bref % 16 == 15));
      check("R8", "decade upper carry", int'(d_tc_hi), int'(dref == 99));
    end
    check("R3", "binary final count", bin_val(), (250 + 300) % 256);
    check("R5", "binary wrapped past 255", bin_val(), 38);
    check("R6", "decade wrapped past 99", dec_val(), 95);
  endtask

  task automatic t_decade_illegal();
    en_par = 1'b1; en_trk = 1'b1;
    for (int v = 10; v < 16; v++) begin
      load_n = 1'b0; d_din_lo = 4'(v); d_din_hi = 4'd0;
      tick();
      load_n = 1'b1;
      check("R7", "illegal digit loaded", int'(d_lo), v);
      tick();
      if (v % 2 == 1) begin
        check("R7", "odd illegal digit step", int'(d_lo), (v + 1) % 8);
      end else begin
        check("R7", "even illegal digit step", int'(d_lo), v + 1);
        tick();
        check("R7", "back in range after two", int'(d_lo), (v + 2) % 8);
      end
      check("R7", "upper digit untouched", int'(d_hi), 0);
    end
  endtask

  task automatic t_reset_style();
    en_par = 1'b0; en_trk = 1'b0;
    load_all(8'h37, 42);
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check("R1", "asynchronous clear before edge", bin_val(), 0);
    check("R1", "synchronous clear waits for edge", dec_val(), 42);
    @(negedge clk);
    check("R1", "synchronous clear after edge", dec_val(), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_priority();
    load_all(8'h81, 64);
    rst_n = 1'b0; load_n = 1'b0; en_par = 1'b1; en_trk = 1'b1;
    tick();
    check("R1", "reset beats load, binary", bin_val(), 0);
    check("R1", "reset beats load, decade", dec_val(), 0);
    rst_n = 1'b1; load_n = 1'b1; en_par = 1'b0; en_trk = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_n = 1'b1; en_par = 1'b0; en_trk = 1'b0;
    b_din_lo = '0; b_din_hi = '0; d_din_lo = '0; d_din_hi = '0;
    @(negedge clk);
    t_reset();
    t_load();
    t_hold();
    t_carry();
    t_count();
    t_decade_illegal();
    t_reset_style();
    t_reset_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule